// File: doc/BRIEF.md
# SPI Master Transfer Controller

This block is a serial master that empties a small transmit queue onto an SPI link and fills a small receive queue from it. Software loads words into a four-entry transmit FIFO. While the engine is enabled, it takes each word in turn and shifts a programmable number of its low bits out on MOSI, most significant bit first. At the same time it shifts the same number of bits in from MISO. Each completed frame is stored right-justified in a four-entry receive FIFO, which software drains with a pop strobe.

A single configuration write sets three things: a soft-reset bit, the frame length and a slave-select enable. The soft-reset bit is set at power-up. While it stays set, the engine is held idle with both queues empty, so nothing moves until software writes it to zero. The serial clock runs only when an external clock-enable strobe is asserted, so the bit rate is chosen outside the block. Data is shifted in SPI mode 0. Frames follow each other with slave select held low until the transmit FIFO runs dry.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After `rst`, the soft-reset bit reads as set. While it is set, `tx_push` is ignored, so `tx_empty` stays 1 and no SCLK activity occurs. A configuration write with `cfg_soft_rst`=0 releases the engine.
- R2: Two cycles after the soft-reset bit is set, and for as long as it stays set: `ss_n`=1, `sclk`=0, `tx_empty`=1, `rx_empty`=1 and `rx_ovf`=0. Setting it in the middle of a frame aborts that frame.
- R3: The transmit FIFO holds 4 words of 32 bits. `tx_full`=1 exactly when 4 words are waiting. A push while it is full is discarded. `tx_empty`=1 when no word is waiting.
- R4: The receive FIFO holds 4 frames. `rx_data` shows the oldest frame, `rx_pop` removes it, and `rx_full`/`rx_empty` report 4 and 0 entries. Frames come out in the order they were received.
- R5: `cfg_len` is 6 bits wide, and its reset value is 8. A written value below 4 is stored as 4, and a value above 32 is stored as 32.
- R6: For a frame length L, bits L-1..0 of the transmit word go out on MOSI with bit L-1 first. The received frame is stored in bits L-1..0 with the upper bits zero, and the first bit received ends up in bit L-1.
- R7: SCLK idles low. MOSI never changes in a cycle in which SCLK rises. MISO is sampled on each SCLK rise.
- R8: A frame starts whenever the engine is idle and the transmit FIFO is not empty. `ss_n` stays low between back-to-back frames and rises once, after the last frame.
- R9: A frame that completes while the receive FIFO is full is discarded, and `rx_ovf` is set. `rx_ovf` stays set until `rst` or the soft-reset bit clears it.
- R10: With `cfg_ss_en`=0, frames are shifted normally but `ss_n` stays high.
- R11: SCLK changes only in the cycle after a cycle with `sclk_en`=1, or when it is forced low by soft reset. A frame of length L takes 2L strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_soft_rst | input | 1 | Soft-reset bit value written on cfg_wr |
| cfg_len | input | 6 | Frame length written on cfg_wr |
| cfg_ss_en | input | 1 | Slave-select enable written on cfg_wr |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Remove the oldest received frame |
| rx_data | output | 32 | Oldest received frame, right-justified |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sclk_en | input | 1 | Serial clock-enable strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A wrong bit counter shows up within a single frame: the bits seen on MOSI at each SCLK rise, or the word that lands in the receive FIFO, come out with the wrong length or shifted by one. A corrupted FIFO pointer or count shows at the next pop as data out of order or repeated, or at once as a full or empty flag that disagrees with the number of pushes and pops. A soft-reset bit stuck at either value shows within two cycles: either SCLK moves while the engine should be held, or nothing moves after release. Every frame length from 4 to 32 is swept, both with MISO looped back and with it inverted, so each length is checked bit for bit.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;

  function automatic int unsigned len_bits(input int unsigned max_len);
    return $clog2(max_len + 1);
  endfunction

endpackage

// File: rtl/spi_xfer_cfg.sv
module spi_xfer_cfg #(
  parameter int unsigned LEN_W   = 6,
  parameter int unsigned MIN_LEN = 4,
  parameter int unsigned MAX_LEN = 32,
  parameter int unsigned RST_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wr_soft,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_ss_en,
  output logic             soft_q,
  output logic [LEN_W-1:0] len_q,
  output logic             ss_en_q
);

  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    if (wr_len < LEN_W'(MIN_LEN))
      len_clamped = LEN_W'(MIN_LEN);
    else if (wr_len > LEN_W'(MAX_LEN))
      len_clamped = LEN_W'(MAX_LEN);
    else
      len_clamped = wr_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q  <= 1'b1;
      len_q   <= LEN_W'(RST_LEN);
      ss_en_q <= 1'b1;
    end else if (wr) begin
      soft_q  <= wr_soft;
      len_q   <= len_clamped;
      ss_en_q <= wr_ss_en;
    end
  end

endmodule

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nxt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop)
      count_nxt = count + CW'(1);
    else if (do_pop && !do_push)
      count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= count_nxt;
      full  <= (count_nxt == CW'(DEPTH));
      empty <= (count_nxt == '0);
    end
  end

  assign rdata = mem[rd_ptr];

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sclk_en,
  input  logic [LEN_W-1:0]  len,
  input  logic              ss_en,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n,
  input  logic              miso
);

  eng_state_e        state_q;
  logic [LEN_W-1:0]  bits_left;
  logic [DATA_W-1:0] tx_sh, rx_sh, tx_aligned;
  logic [LEN_W-1:0]  shamt;
  logic              frame_end, load_go;

  assign shamt      = LEN_W'(DATA_W) - len;
  assign tx_aligned = tx_word << shamt;
  assign frame_end  = (state_q == ENG_SHIFT) && sclk_en && sclk && (bits_left == '0);
  assign load_go    = !clr && !tx_empty && ((state_q == ENG_IDLE) || frame_end);
  assign tx_pop     = load_go;
  assign rx_push    = !clr && frame_end;
  assign rx_word    = rx_sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q   <= ENG_IDLE;
      bits_left <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      ss_n      <= 1'b1;
    end else if (load_go) begin
      state_q   <= ENG_SHIFT;
      bits_left <= len;
      tx_sh     <= tx_aligned;
      mosi      <= tx_aligned[DATA_W-1];
      rx_sh     <= '0;
      sclk      <= 1'b0;
      ss_n      <= !ss_en;
    end else if (frame_end) begin
      state_q <= ENG_IDLE;
      sclk    <= 1'b0;
      ss_n    <= 1'b1;
    end else if ((state_q == ENG_SHIFT) && sclk_en) begin
      if (!sclk) begin
        sclk      <= 1'b1;
        rx_sh     <= {rx_sh[DATA_W-2:0], miso};
        bits_left <= bits_left - LEN_W'(1);
      end else begin
        sclk  <= 1'b0;
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        mosi  <= tx_sh[DATA_W-2];
      end
    end
  end

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned MIN_LEN  = 4,
  parameter int unsigned RST_LEN  = 8,
  parameter int unsigned LEN_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_soft_rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_ss_en,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_ovf,
  input  logic              sclk_en,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);

  logic              soft_q, ss_en_q;
  logic [LEN_W-1:0]  len_q;
  logic              eng_tx_pop, eng_rx_push;
  logic [DATA_W-1:0] tx_head, eng_rx_word;

  spi_xfer_cfg #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(DATA_W),
    .RST_LEN(RST_LEN)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .wr_soft (cfg_soft_rst),
    .wr_len  (cfg_len),
    .wr_ss_en(cfg_ss_en),
    .soft_q  (soft_q),
    .len_q   (len_q),
    .ss_en_q (ss_en_q)
  );

  spi_xfer_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_q),
    .push (tx_push && !soft_q),
    .wdata(tx_data),
    .pop  (eng_tx_pop),
    .rdata(tx_head),
    .full (tx_full),
    .empty(tx_empty)
  );

  spi_xfer_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_q),
    .push (eng_rx_push),
    .wdata(eng_rx_word),
    .pop  (rx_pop && !soft_q),
    .rdata(rx_data),
    .full (rx_full),
    .empty(rx_empty)
  );

  spi_xfer_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .clr     (soft_q),
    .sclk_en (sclk_en),
    .len     (len_q),
    .ss_en   (ss_en_q),
    .tx_empty(tx_empty),
    .tx_word (tx_head),
    .tx_pop  (eng_tx_pop),
    .rx_push (eng_rx_push),
    .rx_word (eng_rx_word),
    .sclk    (sclk),
    .mosi    (mosi),
    .ss_n    (ss_n),
    .miso    (miso)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_q)
      rx_ovf <= 1'b0;
    else if (eng_rx_push && rx_full)
      rx_ovf <= 1'b1;
  end

endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk (
  input logic clk,
  input logic rst,
  input logic soft_q,
  input logic sclk_en,
  input logic sclk,
  input logic mosi,
  input logic ss_n,
  input logic tx_empty,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_ovf
);

  assert_idle_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (soft_q && $past(soft_q)) |-> (ss_n && !sclk && tx_empty && rx_empty && !rx_ovf));

  assert_mosi_steady_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !soft_q) |=> rx_ovf);

  assert_ovf_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $past(rx_full));

  assert_sclk_from_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> ($past(sclk_en) || $past(soft_q)));

endmodule

bind spi_xfer_ctrl spi_xfer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .soft_q  (soft_q),
  .sclk_en (sclk_en),
  .sclk    (sclk),
  .mosi    (mosi),
  .ss_n    (ss_n),
  .tx_empty(tx_empty),
  .rx_empty(rx_empty),
  .rx_full (rx_full),
  .rx_ovf  (rx_ovf)
);

// File: tb/spi_xfer_ctrl_tb.sv
module spi_xfer_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_soft_rst = 1'b1, cfg_ss_en = 1'b1;
  logic [5:0]  cfg_len = 6'd8;
  logic        tx_push = 1'b0, rx_pop = 1'b0, sclk_en = 1'b1;
  logic [31:0] tx_data = '0;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_ovf;
  logic [31:0] rx_data;
  logic        sclk, mosi, miso, ss_n;
  logic        inv = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cur_len = 8;
  int cap_n = 0, obs_n = 0, ss_rises = 0;
  logic [31:0] cap_sh = '0, last_obs = '0;

  always #5 clk = ~clk;

  assign miso = mosi ^ inv;

  spi_xfer_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_soft_rst(cfg_soft_rst),
    .cfg_len(cfg_len), .cfg_ss_en(cfg_ss_en), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovf(rx_ovf), .sclk_en(sclk_en),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always @(posedge sclk) begin
    cap_sh = {cap_sh[30:0], mosi};
    cap_n  = cap_n + 1;
    if (cap_n == cur_len) begin
      last_obs = cap_sh;
      obs_n    = obs_n + 1;
      cap_n    = 0;
      cap_sh   = '0;
    end
  end

  always @(posedge ss_n) ss_rises = ss_rises + 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic s, input logic [5:0] l, input logic e);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_soft_rst = s; cfg_len = l; cfg_ss_en = e;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    tx_push = 1'b1; tx_data = d;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  function automatic logic [31:0] lmask(input int l);
    logic [63:0] m;
    m = (64'd1 << l) - 64'd1;
    return m[31:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    report();
  end

  initial begin
    logic [31:0] w, wv[6];
    int r0, o0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 R2: reset state
    chk(ss_n && !sclk, "R2 reset pins", {30'd0, ss_n, sclk}, 32'd2);
    chk(tx_empty && !tx_full && rx_empty && !rx_full && !rx_ovf, "R2 reset flags",
        {27'd0, tx_empty, tx_full, rx_empty, rx_full, rx_ovf}, 32'h14);
    // R1: push while held is ignored
    push(32'h1234_5678);
    repeat (40) @(negedge clk);
    chk(tx_empty, "R1 push ignored in soft reset", {31'd0, tx_empty}, 32'd1);
    chk(obs_n == 0 && !sclk, "R1 no sclk in soft reset", obs_n, 0);

    // R5 default length 8, R1 release
    cfg(1'b0, 6'd8, 1'b1);
    cur_len = 8;
    w = 32'hCAFE_F00D;
    push(w);
    repeat (30) @(negedge clk);
    chk(rx_data == (w & 32'hFF) && !rx_empty, "R1 R5 release default len", rx_data, w & 32'hFF);
    pop();

    // R6 R7 R11: sweep lengths with loopback and inversion
    for (int l = 4; l <= 32; l++) begin
      cfg(1'b0, 6'(l), 1'b1);
      cur_len = l;
      inv = l[0];
      w = 32'hA5C3_96E1 ^ (32'(l) * 32'h0101_0101);
      push(w);
      repeat (2 * l + 8) @(negedge clk);
      chk(last_obs == (w & lmask(l)), "R6 mosi bits msb first", last_obs, w & lmask(l));
      chk(rx_data == ((inv ? ~w : w) & lmask(l)), "R6 R7 rx right-justified",
          rx_data, (inv ? ~w : w) & lmask(l));
      pop();
    end
    inv = 1'b0;

    // R5 clamp low and high
    cfg(1'b0, 6'd2, 1'b1);
    cur_len = 4;
    push(32'h0000_00B7);
    repeat (20) @(negedge clk);
    chk(rx_data == 32'h7, "R5 clamp to 4", rx_data, 32'h7);
    pop();
    cfg(1'b0, 6'd63, 1'b1);
    cur_len = 32;
    push(32'h8765_4321);
    repeat (72) @(negedge clk);
    chk(rx_data == 32'h8765_4321, "R5 clamp to 32", rx_data, 32'h8765_4321);
    pop();

    // R8 back-to-back frames under one select
    cfg(1'b0, 6'd8, 1'b1);
    cur_len = 8;
    r0 = ss_rises;
    push(32'h11); push(32'h22); push(32'h33);
    repeat (70) @(negedge clk);
    chk(ss_rises - r0 == 1, "R8 single ss_n rise", ss_rises - r0, 1);
    chk(rx_data == 32'h11, "R4 R8 order 0", rx_data, 32'h11); pop();
    chk(rx_data == 32'h22, "R4 R8 order 1", rx_data, 32'h22); pop();
    chk(rx_data == 32'h33, "R4 R8 order 2", rx_data, 32'h33); pop();
    chk(rx_empty, "R4 rx empty after pops", {31'd0, rx_empty}, 32'd1);

    // R3 full / R9 overflow
    sclk_en = 1'b0;
    o0 = obs_n;
    for (int i = 0; i < 6; i++) begin
      wv[i] = 32'h40 + 32'(i) * 32'h13;
      push(wv[i]);
    end
    chk(tx_full && !tx_empty, "R3 tx full after 4 waiting", {30'd0, tx_full, tx_empty}, 32'd2);
    chk(!sclk && $isunknown(sclk) == 0, "R11 no sclk without strobe", {31'd0, sclk}, 32'd0);
    @(negedge clk);
    sclk_en = 1'b1;
    repeat (110) @(negedge clk);
    chk(obs_n - o0 == 5, "R3 push when full dropped", obs_n - o0, 5);
    chk(rx_full && rx_ovf && tx_empty, "R9 overflow set", {29'd0, rx_full, rx_ovf, tx_empty}, 32'd7);
    for (int i = 0; i < 4; i++) begin
      chk(rx_data == (wv[i] & 32'hFF), "R4 R9 kept frames", rx_data, wv[i] & 32'hFF);
      pop();
    end
    chk(rx_empty && rx_ovf, "R9 overflow sticky, fifth dropped", {30'd0, rx_empty, rx_ovf}, 32'd3);
    cfg(1'b1, 6'd8, 1'b1);
    @(negedge clk);
    chk(!rx_ovf, "R9 R2 overflow cleared by soft reset", {31'd0, rx_ovf}, 32'd0);

    // R10 select disabled
    cfg(1'b0, 6'd8, 1'b0);
    r0 = ss_rises;
    o0 = obs_n;
    push(32'h5A);
    repeat (6) @(negedge clk);
    chk(ss_n, "R10 ss_n high mid-frame", {31'd0, ss_n}, 32'd1);
    repeat (20) @(negedge clk);
    chk(obs_n - o0 == 1 && ss_rises == r0 && rx_data == 32'h5A, "R10 frame still shifted",
        rx_data, 32'h5A);
    pop();

    // R2 abort mid-frame
    cfg(1'b0, 6'd16, 1'b1);
    cur_len = 16;
    push(32'hBEEF);
    push(32'h1357);
    repeat (5) @(negedge clk);
    chk(!ss_n, "R8 ss_n low during frame", {31'd0, ss_n}, 32'd0);
    cfg(1'b1, 6'd16, 1'b1);
    @(negedge clk);
    chk(ss_n && !sclk && tx_empty && rx_empty, "R2 abort forces idle",
        {28'd0, ss_n, sclk, tx_empty, rx_empty}, 32'hB);
    push(32'h99);
    repeat (10) @(negedge clk);
    chk(tx_empty && !sclk, "R1 held after re-assert", {30'd0, tx_empty, sclk}, 32'd2);
    report();
  end

endmodule